// File: doc/BRIEF.md
# GPIO Interrupt Summary Aggregator

This block sits between a bank of general-purpose pins and the system interrupt controller. Each pin reports two pending flags, one for an ordinary interrupt and one for a wake event. The block ORs them in groups of four neighbouring pins, giving one summary bit per group, and registers that vector once per clock. Software finds the active group in the summary, then checks only the four pins behind that bit.

The summary is read through a small register port as 32-bit words. A third address holds a master control word. Reading a summary word counts as acknowledgment and silences the combined interrupt line. Software then writes the end-of-interrupt bit after servicing. That bit clears itself one cycle later and also clears the acknowledgment. The line then follows the summary again, so a source that is still pending raises it once more.

Top module: `gpio_irq_summary`

## Requirements
- R1: Summary bit k goes to 1 one clock after any of pins 4k, 4k+1, 4k+2 or 4k+3 presents its interrupt pending flag. No other summary bit changes.
- R2: The wake pending flag of a pin sets its group's summary bit in the same way as the interrupt pending flag.
- R3: A summary bit is not latched. It returns to 0 one clock after all four of its pins show neither flag.
- R4: A read of address 0 returns summary bits 31..0. A read of address 1 returns summary bits 45..32 in data bits 13..0, with data bits 31..14 at 0.
- R5: When no acknowledgment is outstanding, `irq` is 1 exactly while the registered summary is nonzero.
- R6: A read of address 0 or 1 marks an acknowledgment as outstanding. From the next cycle, `irq` stays 0 until an end-of-interrupt has cleared that mark.
- R7: A write to address 2 with data bit 0 set raises the end-of-interrupt flag for exactly one cycle. In the following cycle it clears the outstanding acknowledgment, and `irq` then follows the summary again.
- R8: A read of address 2 returns the outstanding acknowledgment in bit 1 and the end-of-interrupt flag in bit 0, with all other bits 0. A read of address 3 returns 0.
- R9: A write to address 2 with data bit 0 clear has no effect. A write to address 0, 1 or 3 has no effect.
- R10: After reset, the summary, `irq`, the acknowledgment and the end-of-interrupt flag are all 0.
- R11: If a summary read occurs in the same cycle as an active end-of-interrupt flag, the acknowledgment stays outstanding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| int_pend | input | 184 | Interrupt pending flag of each pin |
| wake_pend | input | 184 | Wake pending flag of each pin |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe; a summary read acknowledges |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data, combinational from rd_addr |
| summary | output | 46 | Registered group summary, one bit per four pins |
| irq | output | 1 | Combined interrupt line |

## Verification
The bench targets the pins at the edges of groups and words: pins 3/4, 127/128 and the last pin, 183. A wrong group mapping moves the bit to a neighbouring group. A wrong word split puts bits 45..32 in the wrong place or leaves junk in the unused upper bits. The bench drives a flag that is removed after it was set, to expose a design that latches the summary instead of tracking the pins. It runs the acknowledge and end-of-interrupt sequence cycle by cycle. This catches an end-of-interrupt flag that stays high, a line that never comes back after end-of-interrupt, and a read that fails to silence the line. It also collides a summary read with the end-of-interrupt cycle; a design that lets the clear win would raise the line while software still holds it.

// File: rtl/gpio_irq_summary.sv
module gpio_irq_summary #(
  parameter int NUM_PINS = 184,
  parameter int GROUP    = 4,
  parameter int WORD_W   = 32,
  parameter int ADDR_W   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_PINS-1:0]       int_pend,
  input  logic [NUM_PINS-1:0]       wake_pend,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [WORD_W-1:0]         wr_data,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [WORD_W-1:0]         rd_data,
  output logic [NUM_PINS/GROUP-1:0] summary,
  output logic                      irq
);
  localparam int NUM_GROUPS = NUM_PINS / GROUP;
  localparam int NUM_WORDS  = (NUM_GROUPS + WORD_W - 1) / WORD_W;
  localparam int SUM_W      = NUM_WORDS * WORD_W;
  localparam int NUM_REGS   = 2 ** ADDR_W;
  localparam logic [ADDR_W-1:0] MASTER_ADDR = ADDR_W'(NUM_WORDS);

  logic [NUM_GROUPS-1:0] sum_d, sum_q;
  logic                  eoi_q, await_q;
  logic [SUM_W-1:0]      sum_ext;
  logic [WORD_W-1:0]     master_word;
  logic [WORD_W-1:0]     regs [NUM_REGS];

  wire rd_ack  = rd_en && (rd_addr < MASTER_ADDR);
  wire eoi_set = wr_en && (wr_addr == MASTER_ADDR) && wr_data[0];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
    assign sum_d[g] = |(int_pend[g*GROUP +: GROUP] | wake_pend[g*GROUP +: GROUP]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q   <= '0;
      eoi_q   <= 1'b0;
      await_q <= 1'b0;
    end else begin
      sum_q <= sum_d;
      eoi_q <= eoi_set;
      if (rd_ack)     await_q <= 1'b1;
      else if (eoi_q) await_q <= 1'b0;
    end
  end

  always_comb begin
    sum_ext = '0;
    sum_ext[NUM_GROUPS-1:0] = sum_q;
    master_word    = '0;
    master_word[1] = await_q;
    master_word[0] = eoi_q;
  end

  for (genvar a = 0; a < NUM_REGS; a++) begin : g_reg
    if (a < NUM_WORDS) begin : g_word
      assign regs[a] = sum_ext[a*WORD_W +: WORD_W];
    end else if (a == NUM_WORDS) begin : g_master
      assign regs[a] = master_word;
    end else begin : g_none
      assign regs[a] = '0;
    end
  end

  assign rd_data = regs[rd_addr];
  assign summary = sum_q;
  assign irq     = (|sum_q) && !await_q;
endmodule

// File: rtl/gpio_irq_summary_chk.sv
module gpio_irq_summary_chk #(
  parameter int NUM_PINS = 184,
  parameter int GROUP    = 4,
  parameter int WORD_W   = 32,
  parameter int ADDR_W   = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_PINS-1:0]       int_pend,
  input logic [NUM_PINS-1:0]       wake_pend,
  input logic                      wr_en,
  input logic [ADDR_W-1:0]         wr_addr,
  input logic [WORD_W-1:0]         wr_data,
  input logic                      rd_en,
  input logic [ADDR_W-1:0]         rd_addr,
  input logic [NUM_PINS/GROUP-1:0] summary,
  input logic                      irq,
  input logic                      eoi_q
);
  localparam int NUM_GROUPS = NUM_PINS / GROUP;
  localparam int NUM_WORDS  = (NUM_GROUPS + WORD_W - 1) / WORD_W;
  localparam logic [ADDR_W-1:0] MASTER_ADDR = ADDR_W'(NUM_WORDS);

  wire any_src = (|int_pend) || (|wake_pend);
  wire eoi_wr  = wr_en && (wr_addr == MASTER_ADDR) && wr_data[0];

  assert_any_src_R1: assert property (@(posedge clk) disable iff (!rst_n)
    any_src |=> (|summary));

  assert_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !any_src |=> (summary == '0));

  assert_irq_has_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|summary));

  assert_ack_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (rd_addr < MASTER_ADDR)) |=> !irq);

  assert_eoi_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_wr |=> eoi_q);

  assert_eoi_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_q && !eoi_wr) |=> !eoi_q);
endmodule

bind gpio_irq_summary gpio_irq_summary_chk #(
  .NUM_PINS(NUM_PINS), .GROUP(GROUP), .WORD_W(WORD_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .int_pend(int_pend), .wake_pend(wake_pend),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_en(rd_en), .rd_addr(rd_addr), .summary(summary), .irq(irq),
  .eoi_q(eoi_q)
);

// File: tb/test_gpio_irq_summary.sv
module test_gpio_irq_summary;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 184;
  localparam int NG = 46;
  localparam int NV = 8;
  // pin, kind (0 interrupt, 1 wake), expected summary bit
  localparam int VEC [NV][3] = '{
    '{0, 0, 0}, '{3, 0, 0}, '{4, 0, 1}, '{127, 0, 31},
    '{128, 0, 32}, '{183, 0, 45}, '{90, 1, 22}, '{131, 1, 32}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NP-1:0] int_pend = '0, wake_pend = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [NG-1:0] summary;
  logic irq;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_summary i_gpio_irq_summary (
    .clk(clk), .rst_n(rst_n), .int_pend(int_pend), .wake_pend(wake_pend),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .summary(summary), .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic peek(input logic [1:0] a, output logic [31:0] d);
    rd_en = 1'b0; rd_addr = a; #1; d = rd_data;
  endtask

  task automatic ack_read(input logic [1:0] a, output logic [31:0] d);
    rd_en = 1'b1; rd_addr = a; #1; d = rd_data;
    tick(); rd_en = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick(); wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) tick();
    chk("R10 summary", 64'(summary), 0);
    chk("R10 irq", 64'(irq), 0);
    rst_n = 1'b1;
    tick();
    peek(2'd2, d);
    chk("R10 master", 64'(d), 0);

    for (int i = 0; i < NV; i++) begin
      int_pend = '0; wake_pend = '0;
      if (VEC[i][1] == 0) int_pend[VEC[i][0]] = 1'b1;
      else                wake_pend[VEC[i][0]] = 1'b1;
      tick();
      chk(VEC[i][1] == 0 ? "R1 group bit" : "R2 wake bit",
          64'(summary), 64'(1) << VEC[i][2]);
    end

    int_pend = '0; wake_pend = '0;
    tick();
    chk("R3 all quiet", 64'(summary), 0);
    chk("R5 irq low on empty", 64'(irq), 0);

    int_pend[8] = 1'b1; int_pend[9] = 1'b1;
    tick();
    chk("R5 irq high", 64'(irq), 1);
    int_pend[8] = 1'b0;
    tick();
    chk("R3 partial clear", 64'(summary), 64'(1) << 2);
    int_pend[9] = 1'b0;
    tick();
    chk("R3 group cleared", 64'(summary), 0);

    int_pend[0] = 1'b1; int_pend[128] = 1'b1; wake_pend[183] = 1'b1;
    tick();
    chk("R5 irq before ack", 64'(irq), 1);
    peek(2'd1, d);
    chk("R4 word1", 64'(d), 64'h2001);
    ack_read(2'd0, d);
    chk("R4 word0", 64'(d), 1);
    chk("R6 irq after ack", 64'(irq), 0);
    peek(2'd2, d);
    chk("R8 master ack bit", 64'(d), 2);
    peek(2'd3, d);
    chk("R8 unused addr", 64'(d), 0);

    wr(2'd2, 32'hFFFF_FFFE);
    peek(2'd2, d);
    chk("R9 eoi bit clear write", 64'(d), 2);
    chk("R9 irq stays low", 64'(irq), 0);
    wr(2'd0, 32'hFFFF_FFFF);
    wr(2'd3, 32'hFFFF_FFFF);
    peek(2'd2, d);
    chk("R9 other addr write", 64'(d), 2);
    chk("R9 summary intact", 64'(summary), (64'(1) << 45) | (64'(1) << 32) | 64'(1));

    tick();
    chk("R6 irq held", 64'(irq), 0);
    wr(2'd2, 32'h1);
    peek(2'd2, d);
    chk("R7 eoi pulse", 64'(d), 3);
    chk("R7 irq still low", 64'(irq), 0);
    tick();
    peek(2'd2, d);
    chk("R7 eoi self clear", 64'(d), 0);
    chk("R7 irq returns", 64'(irq), 1);

    ack_read(2'd1, d);
    chk("R6 second ack", 64'(irq), 0);
    wr(2'd2, 32'h1);
    ack_read(2'd0, d);
    peek(2'd2, d);
    chk("R11 ack survives eoi", 64'(d), 2);
    chk("R11 irq low", 64'(irq), 0);

    wr(2'd2, 32'h1);
    int_pend = '0; wake_pend = '0;
    tick();
    chk("R5 irq low after eoi, empty", 64'(irq), 0);
    peek(2'd2, d);
    chk("R7 flags clear", 64'(d), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule